// File: doc/BRIEF.md
# Two-Channel Memory-Mapped PWM with Pending-Write Flags

The block is a pulse-width modulator bank behind a plain single-cycle register bus. Each channel runs a prescaler feeding a period counter. Its output is driven while the period counter sits below the duty value, and can be inverted. Software programs a channel through four registers per slot, and the slots sit 16 bytes apart. A shared status word reports, per register, whether a write is still on its way into the running logic. Software polls that word until the write has landed.

A write reaches a channel's programmed register at once, and reads return the programmed value. The copy into the counting logic happens a fixed number of cycles later, and the pending flag is high for that whole interval. With autoload on, new timing values wait in shadow registers until the period wraps. Two control bits let a prescaler or period change bypass that wait. Disabling a channel either stops it at once or lets it finish its current period.

Each channel is sequenced by a three-state machine. The states are IDLE (counters held at zero, output at its inactive level), RUN (counting) and DRAIN (disabled, finishing the period). The transitions are: IDLE→RUN when the effective enable rises; RUN→IDLE when enable falls with stop-now set; RUN→DRAIN when enable falls with stop-now clear; DRAIN→RUN when enable returns; DRAIN→IDLE on stop-now or at the period wrap.

Top module: `pwm_bank`

## Requirements
- R1: Channel c's registers are at byte address 16·c plus 0x0 (control), 0x4 (prescaler), 0x8 (period) and 0xC (duty). Address bits 1:0 are ignored. A write updates the programmed value on the next clock edge, and a read returns it zero-extended. Widths are 6 bits for control, 10 for the prescaler, and 12 for period and duty.
- R2: Slots 2 and 3 (0x20–0x3F) and every address above 0x40 read as zero, and writes to them change nothing.
- R3: The status word at 0x40 holds channel c's flags at bits 8·c+0 (control), 8·c+1 (prescaler), 8·c+2 (period) and 8·c+3 (duty). All other bits are zero, and writes to 0x40 are ignored.
- R4: A register's pending flag reads 1 for exactly 4 cycles after the edge that captures its write, then 0. A new write to the same register restarts the 4 cycles.
- R5: With autoload (control bit 2) clear, a new prescaler, period or duty value enters the counting logic on the edge where its pending flag clears.
- R6: With autoload set, a transferred prescaler, period or duty value is held in a shadow register. It enters the counting logic only at the wrap at the end of a period.
- R7: While running, one period lasts (P+1)·(N+1) clocks, where P is the prescaler and N the period value. The uninverted output is 1 while the period counter is below the duty value, so duty 0 gives a constant 0 and a duty above N gives a constant 1.
- R8: Control bit 1 inverts the output in every state, including the inactive level in IDLE.
- R9: When the effective enable (control bit 0) rises, the channel starts at count 0 with a fresh prescale interval.
- R10: When enable falls with stop-now (control bit 3) set, the output becomes inactive and the counters reset on the same edge where the control pending flag clears.
- R11: When enable falls with stop-now clear, the channel keeps producing its waveform until the current period wraps, and then goes inactive.
- R12: The two channels count, transfer and report status independently.
- R13: Under autoload, control bit 4 makes prescaler writes take effect when they transfer, and control bit 5 does the same for period writes. Duty still waits for the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counters |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte address |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 2 | Channel outputs, bit c for channel c |

## Verification
The status word is visible on every cycle the bus is idle, so a wrong pending counter appears within one cycle of the write. That includes an off-by-one transfer edge or a lost restart. A wrong active value, a shadow copied at the wrong time or a bad FSM transition shows at the pins within one prescaled tick. This is because the output follows the state, the period counter and the duty value on every clock. The bench tracks its own model of each channel and compares both pins and the read port every cycle. Glitches of a single cycle at transfer and wrap edges therefore cannot hide.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // Register index inside a channel slot (address bits 3:2)
    localparam int NREG     = 4;
    localparam int REG_CTRL = 0;
    localparam int REG_PSC  = 1;
    localparam int REG_PER  = 2;
    localparam int REG_DUTY = 3;

    // Control field positions
    localparam int CTRL_W   = 6;
    localparam int CB_EN    = 0;
    localparam int CB_INV   = 1;
    localparam int CB_AUTO  = 2;
    localparam int CB_STOP  = 3;
    localparam int CB_LDPSC = 4;
    localparam int CB_LDPER = 5;

    // Stride between channel slots in bytes, and status lane width per channel
    localparam int SLOT_BYTES = 16;
    localparam int STAT_LANE  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } chan_state_e;

endpackage

// File: rtl/pwm_pend.sv
// Fixed-length transfer delay for one register; busy while a write is in flight.
module pwm_pend #(
    parameter int SYNC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    output logic busy,
    output logic commit
);
    localparam int CW = $clog2(SYNC_CYC + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (wr) begin
            left_q <= CW'(SYNC_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy   = (left_q != '0);
    assign commit = (left_q == CW'(1)) && !wr;

    // R4: a captured write is visible as pending on the next cycle
    p_pend_set_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> busy);

    // R4: the transfer edge ends the pending window
    p_commit_clear_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
#(
    parameter int PSC_W    = 10,
    parameter int PER_W    = 12,
    parameter int VW       = 12,
    parameter int SYNC_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] wr,
    input  logic [VW-1:0]   wdata,
    input  logic [1:0]      rd_sel,
    output logic [VW-1:0]   rd_val,
    output logic [NREG-1:0] pend,
    output logic            pwm
);

    logic [NREG-1:0] commit;

    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_pend
            pwm_pend #(.SYNC_CYC(SYNC_CYC)) u_pend (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr     (wr[r]),
                .busy   (pend[r]),
                .commit (commit[r])
            );
        end
    endgenerate

    // ---------------- programmed (bus-visible) registers ----------------
    logic [CTRL_W-1:0] prog_ctrl;
    logic [PSC_W-1:0]  prog_psc;
    logic [PER_W-1:0]  prog_per;
    logic [PER_W-1:0]  prog_duty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_ctrl <= '0;
            prog_psc  <= '0;
            prog_per  <= '0;
            prog_duty <= '0;
        end else begin
            if (wr[REG_CTRL]) prog_ctrl <= wdata[CTRL_W-1:0];
            if (wr[REG_PSC])  prog_psc  <= wdata[PSC_W-1:0];
            if (wr[REG_PER])  prog_per  <= wdata[PER_W-1:0];
            if (wr[REG_DUTY]) prog_duty <= wdata[PER_W-1:0];
        end
    end

    always_comb begin
        unique case (rd_sel)
            2'd0:    rd_val = VW'(prog_ctrl);
            2'd1:    rd_val = VW'(prog_psc);
            2'd2:    rd_val = VW'(prog_per);
            default: rd_val = VW'(prog_duty);
        endcase
    end

    // ---------------- effective control, shadows, active values ----------------
    logic [CTRL_W-1:0] eff_ctrl, ctrl_nx;
    logic [PSC_W-1:0]  sh_psc, sh_psc_n, act_psc;
    logic [PER_W-1:0]  sh_per, sh_per_n, act_per;
    logic [PER_W-1:0]  sh_duty, sh_duty_n, act_duty;
    logic              auto_ld, dir_psc, dir_per, dir_duty;

    chan_state_e       state_q, state_d;
    logic [PSC_W-1:0]  pc_q;
    logic [PER_W-1:0]  cnt_q;
    logic              running, tick, wrap;

    assign ctrl_nx   = commit[REG_CTRL] ? prog_ctrl : eff_ctrl;
    assign auto_ld   = eff_ctrl[CB_AUTO];
    assign dir_psc   = !auto_ld || eff_ctrl[CB_LDPSC];
    assign dir_per   = !auto_ld || eff_ctrl[CB_LDPER];
    assign dir_duty  = !auto_ld;

    assign sh_psc_n  = commit[REG_PSC]  ? prog_psc  : sh_psc;
    assign sh_per_n  = commit[REG_PER]  ? prog_per  : sh_per;
    assign sh_duty_n = commit[REG_DUTY] ? prog_duty : sh_duty;

    assign running   = (state_q != ST_IDLE);
    assign tick      = running && (pc_q >= act_psc);
    assign wrap      = tick && (cnt_q >= act_per);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_ctrl <= '0;
            sh_psc   <= '0;
            sh_per   <= '0;
            sh_duty  <= '0;
            act_psc  <= '0;
            act_per  <= '0;
            act_duty <= '0;
        end else begin
            eff_ctrl <= ctrl_nx;
            sh_psc   <= sh_psc_n;
            sh_per   <= sh_per_n;
            sh_duty  <= sh_duty_n;

            if (commit[REG_PSC] && dir_psc)      act_psc <= prog_psc;
            else if (auto_ld && wrap)            act_psc <= sh_psc_n;

            if (commit[REG_PER] && dir_per)      act_per <= prog_per;
            else if (auto_ld && wrap)            act_per <= sh_per_n;

            if (commit[REG_DUTY] && dir_duty)    act_duty <= prog_duty;
            else if (auto_ld && wrap)            act_duty <= sh_duty_n;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_nx[CB_EN]) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!ctrl_nx[CB_EN]) state_d = ctrl_nx[CB_STOP] ? ST_IDLE : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (ctrl_nx[CB_EN])        state_d = ST_RUN;
                else if (ctrl_nx[CB_STOP]) state_d = ST_IDLE;
                else if (wrap)             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            cnt_q <= '0;
        end else if (state_d == ST_IDLE || state_q == ST_IDLE) begin
            pc_q  <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pc_q  <= '0;
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end else begin
            pc_q  <= pc_q + 1'b1;
        end
    end

    // ---------------- output process ----------------
    always_comb begin
        pwm = (running && (cnt_q < act_duty)) ^ eff_ctrl[CB_INV];
    end

    // R8: an idle channel sits at its inactive level, set by the invert bit
    p_idle_level_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (pwm == eff_ctrl[CB_INV]));

    // R10: disable with stop-now lands in IDLE with cleared count on the transfer edge
    p_stop_now_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (commit[REG_CTRL] && !prog_ctrl[CB_EN] && prog_ctrl[CB_STOP])
        |=> (state_q == ST_IDLE && cnt_q == '0 && pc_q == '0));

    // R9: counting starts from zero whenever the channel leaves IDLE
    p_start_zero_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (cnt_q == '0 && pc_q == '0));

    // R11: a draining channel stops at the wrap unless re-enabled or stopped
    p_drain_done_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && wrap && !ctrl_nx[CB_EN]) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int SLOTS    = 4,
    parameter int PSC_W    = 10,
    parameter int PER_W    = 12,
    parameter int SYNC_CYC = 4,
    parameter int AW       = 7,
    parameter int DW       = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_we,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    localparam int STAT_ADDR = SLOTS * SLOT_BYTES;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int VW        = (PER_W > PSC_W) ? PER_W : PSC_W;
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

    logic              in_space, stat_hit, unimpl;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        rsel;
    logic              unused_bits;

    assign in_space    = (bus_addr < STAT_A);
    assign stat_hit    = (bus_addr[AW-1:2] == STAT_A[AW-1:2]);
    assign slot        = bus_addr[4 +: SLOT_W];
    assign rsel        = bus_addr[3:2];
    assign unimpl      = !stat_hit && !(in_space && (int'(slot) < NCH));
    assign unused_bits = ^{bus_wdata[DW-1:VW], bus_addr[1:0]};

    logic [NREG-1:0] ch_wr    [NCH];
    logic [NREG-1:0] pend_all [NCH];
    logic [VW-1:0]   chan_rd  [NCH];

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            assign ch_wr[c] = (bus_we && in_space && slot == SLOT_W'(c))
                              ? (NREG'(1) << rsel) : '0;

            pwm_chan #(
                .PSC_W    (PSC_W),
                .PER_W    (PER_W),
                .VW       (VW),
                .SYNC_CYC (SYNC_CYC)
            ) u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr     (ch_wr[c]),
                .wdata  (bus_wdata[VW-1:0]),
                .rd_sel (rsel),
                .rd_val (chan_rd[c]),
                .pend   (pend_all[c]),
                .pwm    (pwm_out[c])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (stat_hit) begin
            for (int k = 0; k < NCH; k++) begin
                bus_rdata[STAT_LANE*k +: NREG] = pend_all[k];
            end
        end else if (in_space) begin
            for (int k = 0; k < NCH; k++) begin
                if (slot == SLOT_W'(k)) bus_rdata = DW'(chan_rd[k]);
            end
        end
    end

    // R2: reserved slots and addresses past the status word read as zero
    p_unimpl_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        unimpl |-> (bus_rdata == '0));

endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
    localparam int NCH  = 2;
    localparam int STAT = 'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = 7'(STAT);
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit model_on = 0;

    always #4 clk = ~clk;   // 125 MHz

    pwm_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // ---------------- behavioural reference model ----------------
    int unsigned m_prog [NCH][4];
    int unsigned m_pend [NCH][4];
    int unsigned m_sh   [NCH][4];
    int unsigned m_act  [NCH][4];   // [0] = effective control
    int unsigned m_st   [NCH];      // 0 idle, 1 run, 2 drain
    int unsigned m_pc   [NCH];
    int unsigned m_cnt  [NCH];

    function automatic int unsigned fmask(int r);
        case (r)
            0: return 'h3F;
            1: return 'h3FF;
            default: return 'hFFF;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                for (int r = 0; r < 4; r++) begin
                    m_prog[ch][r] = 0; m_pend[ch][r] = 0;
                    m_sh[ch][r] = 0;   m_act[ch][r] = 0;
                end
                m_st[ch] = 0; m_pc[ch] = 0; m_cnt[ch] = 0;
            end
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                bit wr [4];
                bit cm [4];
                int unsigned eff, nx, shn [4], nst;
                bit al, tick, wrap, running;
                for (int r = 0; r < 4; r++) begin
                    wr[r] = bus_we && (int'(bus_addr) < STAT) && (int'(bus_addr) / 16 == ch)
                            && ((int'(bus_addr) / 4) % 4 == r);
                    cm[r] = (m_pend[ch][r] == 1) && !wr[r];
                    shn[r] = cm[r] ? m_prog[ch][r] : m_sh[ch][r];
                end
                eff = m_act[ch][0];
                al = eff[2];
                nx = cm[0] ? m_prog[ch][0] : eff;
                running = (m_st[ch] != 0);
                tick = running && (m_pc[ch] >= m_act[ch][1]);
                wrap = tick && (m_cnt[ch] >= m_act[ch][2]);
                nst = m_st[ch];
                if (m_st[ch] == 0) begin
                    if (nx[0]) nst = 1;
                end else if (m_st[ch] == 1) begin
                    if (!nx[0]) nst = nx[3] ? 0 : 2;
                end else begin
                    if (nx[0]) nst = 1;
                    else if (nx[3] || wrap) nst = 0;
                end
                for (int r = 1; r < 4; r++) begin
                    bit direct;
                    direct = !al || (r == 1 && eff[4]) || (r == 2 && eff[5]);
                    if (cm[r] && direct) m_act[ch][r] = m_prog[ch][r];
                    else if (al && wrap) m_act[ch][r] = shn[r];
                    m_sh[ch][r] = shn[r];
                end
                m_act[ch][0] = nx;
                if (nst == 0 || m_st[ch] == 0) begin
                    m_pc[ch] = 0; m_cnt[ch] = 0;
                end else if (tick) begin
                    m_pc[ch] = 0;
                    m_cnt[ch] = wrap ? 0 : m_cnt[ch] + 1;
                end else begin
                    m_pc[ch] = m_pc[ch] + 1;
                end
                m_st[ch] = nst;
                for (int r = 0; r < 4; r++) begin
                    if (wr[r]) begin
                        m_prog[ch][r] = bus_wdata & fmask(r);
                        m_pend[ch][r] = 4;
                    end else if (m_pend[ch][r] != 0) begin
                        m_pend[ch][r] = m_pend[ch][r] - 1;
                    end
                end
            end
        end
    end

    function automatic int unsigned exp_out(int ch);
        int unsigned e;
        e = m_act[ch][0];
        return ((m_st[ch] != 0 && m_cnt[ch] < m_act[ch][3]) ? 1 : 0) ^ e[1];
    endfunction

    function automatic int unsigned exp_rd(int a);
        int unsigned v = 0;
        if (a >= STAT) begin
            if (a / 4 == STAT / 4)
                for (int ch = 0; ch < NCH; ch++)
                    for (int r = 0; r < 4; r++)
                        if (m_pend[ch][r] != 0) v = v | (1 << (8 * ch + r));
            return v;
        end
        if (a / 16 < NCH) return m_prog[a / 16][(a / 4) % 4];
        return 0;
    endfunction

    task automatic chk(string tag, int unsigned got, int unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            for (int ch = 0; ch < NCH; ch++)
                chk($sformatf("%s pwm_out[%0d]", cur_req, ch), 32'(pwm_out[ch]), exp_out(ch));
            chk($sformatf("%s rdata@0x%0h", cur_req, bus_addr), bus_rdata, exp_rd(int'(bus_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bw(int a, int unsigned d);
        @(posedge clk); #1;
        bus_addr = 7'(a); bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = 7'(STAT);
    endtask

    task automatic rd_chk(int a, int unsigned exp, string tag);
        @(posedge clk); #1;
        bus_addr = 7'(a);
        @(negedge clk);
        chk(tag, bus_rdata, exp);
        @(posedge clk); #1;
        bus_addr = 7'(STAT);
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        int hi;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        model_on = 1;

        // Reset state
        rd_chk('h00, 0, "R1 reset ctrl");
        rd_chk('h18, 0, "R1 reset period");
        rd_chk(STAT, 0, "R3 reset status");

        // R1: readback and field widths
        bw('h04, 32'hFFFF_FFFF);
        rd_chk('h04, 'h3FF, "R1 prescaler width");
        bw('h08, 32'hFFFF_F123);
        rd_chk('h08, 'h123, "R1 period width");
        bw('h1F, 32'h0000_0ABC);           // low address bits ignored -> ch1 duty
        rd_chk('h1C, 'hABC, "R1 duty with low addr bits");
        bw('h00, 32'hC0);
        rd_chk('h00, 0, "R1 control width");

        // R2: unimplemented space
        cur_req = "R2";
        bw('h24, 'h55);
        bw('h30, 'h1);
        bw('h48, 'h77);
        rd_chk('h24, 0, "R2 slot2 reads zero");
        rd_chk('h30, 0, "R2 slot3 reads zero");
        rd_chk('h48, 0, "R2 above status reads zero");
        idle(8);
        chk("R2 no output from slot writes", 32'(pwm_out), 0);

        // R3: status is read-only
        cur_req = "R3";
        bw(STAT, 'hFFFF);
        @(negedge clk);
        chk("R3 status write ignored", bus_rdata, 0);

        // R4: pending window length and restart
        cur_req = "R4";
        idle(2);
        bw('h1C, 3);
        @(negedge clk);
        chk("R4 ch1 duty flag at bit 11", bus_rdata, 'h800);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 flag still set in 4th cycle", bus_rdata, 'h800);
        @(negedge clk);
        chk("R4 flag cleared after 4 cycles", bus_rdata, 0);
        bw('h04, 1);
        idle(2);
        bw('h04, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 rewrite restarts window", bus_rdata, 'h2);
        idle(4);

        // R7: period and duty
        cur_req = "R7";
        bw('h04, 1); bw('h08, 4); bw('h0C, 2); bw('h00, 'h1);
        idle(30);
        @(negedge clk);
        while (!(pwm_out[0] === 1'b1)) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            if (pwm_out[0] === 1'b1) hi++;
            @(negedge clk);
        end
        chk("R7 high clocks per 10-clock period", hi, 4);
        chk("R7 next period starts high", 32'(pwm_out[0]), 1);

        // R8: inversion
        cur_req = "R8";
        bw('h00, 'h3);
        idle(40);

        // R5: direct updates without autoload
        cur_req = "R5";
        bw('h08, 6);
        idle(30);
        bw('h0C, 5);
        idle(30);

        // R6: autoload shadowing
        cur_req = "R6";
        bw('h00, 'h7);
        idle(10);
        bw('h08, 2);
        bw('h0C, 1);
        idle(50);

        // R13: load-bypass bits under autoload
        cur_req = "R13";
        bw('h00, 'h37);
        idle(8);
        bw('h04, 3);
        bw('h08, 5);
        bw('h0C, 4);
        idle(80);

        // R12: second channel in parallel
        cur_req = "R12";
        bw('h14, 0); bw('h18, 3); bw('h1C, 1); bw('h10, 'h1);
        idle(60);

        // R11: disable without stop-now drains
        cur_req = "R11";
        bw('h00, 'h2);
        idle(80);
        @(negedge clk);
        chk("R11 drained channel idles at inverted level", 32'(pwm_out[0]), 1);

        // R9: re-enable starts fresh
        cur_req = "R9";
        bw('h00, 'h1);
        idle(40);

        // R10: stop-now
        cur_req = "R10";
        bw('h0C, 'hFFF);
        idle(30);
        bw('h00, 'h8);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 still driven before transfer", 32'(pwm_out[0]), 1);
        @(negedge clk);
        chk("R10 inactive on transfer edge", 32'(pwm_out[0]), 0);
        idle(20);

        // R7 corners: duty zero and duty above period on channel 1
        cur_req = "R7";
        bw('h1C, 0);
        idle(30);
        bw('h1C, 'hFFF);
        idle(30);

        model_on = 0;
        summary();
        $finish;
    end
endmodule